// File: doc/BRIEF.md
# Power-Cycling Watchdog Supervisor

This block decides whether a monitored processor receives its supply. After reset it keeps the supply off for as long as the active-low manual-reset input stays low. When that input goes high, the block counts a power-off interval in ticks and then asserts the power-enable output. While power is on, every edge of the watchdog strobe restarts a timeout. The strobe may rise or fall. If the timeout runs out, or if the manual reset goes low, the block removes power at once. It then runs the whole power-up sequence again, which guarantees a minimum off time before the processor is powered once more.

A single saturating counter measures both intervals. The counter advances only on cycles where the tick-enable input is high, and the surrounding logic supplies a tick of about 8 ms. Both the manual reset and the strobe pass through two-flop synchronizers before the block makes any decision on them. An inhibit input holds the watchdog count at zero, so a strobe line that is left floating cannot trigger a timeout.

Top module: `pwr_supervisor`

## Requirements
- R1: After reset, and for as long as the synchronized manual reset stays low in the hold state, `pwr_en_o` is 0 and `state_o` is 2'b00 (hold).
- R2: When the manual reset reads high, the block enters the counting state (2'b01). After PWR_OFF_TICKS ticks it enables power. Measured from the input change, `pwr_en_o` rises after PWR_OFF_TICKS+3 clock edges when a tick occurs every cycle.
- R3: The interval counter advances only on cycles with `tick_i` high. With no ticks, power stays on without any strobe activity.
- R4: A rising edge and a falling edge of `wd_strobe_i` each clear the watchdog count, and a strobe period that stays within the limit keeps power on indefinitely.
- R5: A timeout occurs only when the count is strictly greater than WD_TICKS. With ticks every cycle from a count of zero, power drops on the (WD_TICKS+2)-th edge, and the state returns to hold (2'b00).
- R6: A low manual reset removes power from any state within three clock edges, because of the two synchronizer flops plus the state register. A low manual reset during the counting state also aborts the count.
- R7: While `wd_inhibit_i` is high, the watchdog count is held at zero and no timeout occurs. After the inhibit is released, the full WD_TICKS+2 edge window applies.
- R8: After a watchdog fault with the manual reset high, power comes back PWR_OFF_TICKS+1 edges after the block enters the hold state.
- R9: `state_o` encodes hold as 2'b00, counting as 2'b01 and powered as 2'b10, and `pwr_en_o` is high exactly in the powered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mrst_ni | input | 1 | Manual reset, active low, asynchronous to clk_i |
| wd_strobe_i | input | 1 | Watchdog strobe; either edge restarts the timeout |
| tick_i | input | 1 | Tick enable for the interval counter |
| wd_inhibit_i | input | 1 | Holds the watchdog count at zero while high |
| pwr_en_o | output | 1 | Supply enable for the monitored processor |
| state_o | output | 2 | Current state: 00 hold, 01 counting, 10 powered |

## Verification
The hardest case to reach is the exact timeout boundary. To hit it, the counter must start from a known value of zero, and no strobe edge may be in flight through the synchronizer. The stimulus therefore first freezes the counter by stopping the ticks. It then sends a strobe edge and waits until that edge has cleared the count. Finally it restores ticks every cycle, so the fall of power can be counted to the edge and lands just past WD_TICKS. The inhibit release and the recovery after a fault use the same method: the counter is pinned at zero before the window is measured. A behavioural model also tracks the state every cycle.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  typedef enum logic [1:0] {
    ST_OFF_HOLD  = 2'b00,
    ST_OFF_COUNT = 2'b01,
    ST_POWER_ON  = 2'b10
  } sup_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= rst_val_i;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_interval_cnt.sv
module sup_interval_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R3: count never wraps
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  // R3: without a tick or clear the count holds
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import pwr_sup_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int PWR_OFF_TICKS = 122,
  parameter int WD_TICKS      = 61
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mr_s_i,
  input  logic             stb_s_i,
  input  logic             tick_i,
  input  logic             inhibit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output sup_state_e       state_o
);
  localparam logic [CNT_W-1:0] PO_LAST = CNT_W'(PWR_OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] WD_LIM  = CNT_W'(WD_TICKS);

  sup_state_e state_q, state_d;
  logic       stb_prev_q;
  logic       stb_edge;
  logic       wd_expired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF_HOLD;
      stb_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      stb_prev_q <= stb_s_i;
    end
  end

  assign stb_edge   = stb_s_i ^ stb_prev_q;
  assign wd_expired = cnt_i > WD_LIM;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (state_q)
      ST_OFF_HOLD: begin
        cnt_clr_o = 1'b1;
        if (mr_s_i) state_d = ST_OFF_COUNT;
      end
      ST_OFF_COUNT: begin
        if (!mr_s_i) begin
          state_d   = ST_OFF_HOLD;
          cnt_clr_o = 1'b1;
        end else if (tick_i) begin
          if (cnt_i == PO_LAST) begin
            state_d   = ST_POWER_ON;
            cnt_clr_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
      end
      ST_POWER_ON: begin
        if (!mr_s_i || wd_expired) begin
          state_d   = ST_OFF_HOLD;
          cnt_clr_o = 1'b1;
        end else if (inhibit_i || stb_edge) begin
          cnt_clr_o = 1'b1;
        end else if (tick_i) begin
          cnt_inc_o = 1'b1;
        end
      end
      default: begin
        state_d   = ST_OFF_HOLD;
        cnt_clr_o = 1'b1;
      end
    endcase
  end

  assign state_o = state_q;

  // R1: hold persists while manual reset is low
  a_r1_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF_HOLD && !mr_s_i) |=> state_q == ST_OFF_HOLD);
  // R2: power never comes straight from hold
  a_r2_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OFF_HOLD |=> state_q != ST_POWER_ON);
  // R4: a strobe edge clears the count while powered
  a_r4_edge_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWER_ON && mr_s_i && cnt_i <= WD_LIM && stb_edge) |=> cnt_i == '0);
  // R5: expired count drops power
  a_r5_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWER_ON && cnt_i > WD_LIM) |=> state_q == ST_OFF_HOLD);
  // R6: low manual reset removes power
  a_r6_mr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_s_i |=> state_q == ST_OFF_HOLD);
  // R7: inhibit keeps the count at zero
  a_r7_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POWER_ON && mr_s_i && inhibit_i && cnt_i <= WD_LIM) |=> cnt_i == '0);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int PWR_OFF_TICKS = 122,
  parameter int WD_TICKS      = 61,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mrst_ni,
  input  logic       wd_strobe_i,
  input  logic       tick_i,
  input  logic       wd_inhibit_i,
  output logic       pwr_en_o,
  output logic [1:0] state_o
);
  localparam int CNT_MAXV = (PWR_OFF_TICKS > WD_TICKS + 1) ? PWR_OFF_TICKS : WD_TICKS + 1;
  localparam int CNT_W    = $clog2(CNT_MAXV + 2);

  logic [1:0]       sync_in, sync_out;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;
  sup_state_e       state;

  assign sync_in = {mrst_ni, wd_strobe_i};

  sup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      (sync_in),
    .rst_val_i(2'b00),
    .q_o      (sync_out)
  );

  sup_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  sup_ctrl #(
    .CNT_W        (CNT_W),
    .PWR_OFF_TICKS(PWR_OFF_TICKS),
    .WD_TICKS     (WD_TICKS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mr_s_i   (sync_out[1]),
    .stb_s_i  (sync_out[0]),
    .tick_i   (tick_i),
    .inhibit_i(wd_inhibit_i),
    .cnt_i    (cnt),
    .cnt_clr_o(cnt_clr),
    .cnt_inc_o(cnt_inc),
    .state_o  (state)
  );

  assign pwr_en_o = (state == ST_POWER_ON);
  assign state_o  = state;

  // R9: power rises only out of the counting state
  a_r9_rise_from_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> $past(state) == ST_OFF_COUNT);
endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;
  localparam int PO = 6;
  localparam int WD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mr = 1'b0, stb = 1'b0, tick = 1'b1, inh = 1'b0;
  logic pwr_en;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_supervisor #(.PWR_OFF_TICKS(PO), .WD_TICKS(WD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mrst_ni(mr), .wd_strobe_i(stb),
    .tick_i(tick), .wd_inhibit_i(inh), .pwr_en_o(pwr_en), .state_o(state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference: input delay queues plus a mode/count pair
  int mr_q[$], stb_q[$];
  int m_mode, m_cnt, m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q = '{0, 0}; stb_q = '{0, 0};
      m_mode = 0; m_cnt = 0; m_prev = 0;
    end else begin
      int mrs, sts;
      mrs = mr_q[1]; sts = stb_q[1];
      case (m_mode)
        0: begin m_cnt = 0; if (mrs == 1) m_mode = 1; end
        1: if (mrs == 0) begin m_mode = 0; m_cnt = 0; end
           else if (tick) begin
             if (m_cnt + 1 == PO) begin m_mode = 2; m_cnt = 0; end
             else m_cnt++;
           end
        default: if (mrs == 0 || m_cnt > WD) begin m_mode = 0; m_cnt = 0; end
           else if (inh || sts != m_prev) m_cnt = 0;
           else if (tick) m_cnt++;
      endcase
      m_prev = sts;
      void'(mr_q.pop_back()); mr_q.push_front(int'(mr));
      void'(stb_q.pop_back()); stb_q.push_front(int'(stb));
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int exp_st;
    exp_st = (m_mode == 0) ? 0 : (m_mode == 1) ? 1 : 2;
    chk(state == 2'(exp_st), "R9 state vs model", int'(state), exp_st);
    chk(pwr_en == (m_mode == 2), "R9 pwr_en vs model", int'(pwr_en), int'(m_mode == 2));
  end

  task automatic edges_until(input bit want, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (pwr_en != want && n < 500);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pwr_en == 0 && state == 2'b00, "R1 reset state", int'(state), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(pwr_en == 0, "R1 off while mr low", int'(pwr_en), 0);
    chk(state == 2'b00, "R1 hold while mr low", int'(state), 0);

    // R2 power-up sequence
    mr = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk(state == 2'b01, "R2 counting state", int'(state), 1);
    edges_until(1'b1, n);
    chk(n + 3 == PO + 3, "R2 power-up edges", n + 3, PO + 3);

    // R4 both edges keep power on
    for (int i = 0; i < 20; i++) begin
      stb = ~stb;
      repeat (3) @(negedge clk);
    end
    chk(pwr_en == 1, "R4 strobing keeps power", int'(pwr_en), 1);

    // R3 no ticks: no advance
    tick = 1'b0;
    repeat (40) @(negedge clk);
    chk(pwr_en == 1, "R3 frozen without ticks", int'(pwr_en), 1);

    // R5 exact boundary from a count of zero
    stb = ~stb;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    edges_until(1'b0, n);
    chk(n == WD + 2, "R5 timeout edge", n, WD + 2);
    chk(state == 2'b00, "R5 back to hold", int'(state), 0);

    // R8 recovery after fault
    edges_until(1'b1, n);
    chk(n == PO + 1, "R8 recovery edges", n, PO + 1);

    // R7 inhibit
    inh = 1'b1;
    repeat (50) @(negedge clk);
    chk(pwr_en == 1, "R7 inhibit holds power", int'(pwr_en), 1);
    inh = 1'b0;
    edges_until(1'b0, n);
    chk(n == WD + 2, "R7 window after release", n, WD + 2);
    edges_until(1'b1, n);
    chk(n == PO + 1, "R8 second recovery", n, PO + 1);

    // R6 manual reset while powered
    mr = 1'b0;
    edges_until(1'b0, n);
    chk(n == 3, "R6 mr latency", n, 3);
    repeat (20) @(negedge clk);
    chk(pwr_en == 0 && state == 2'b00, "R1 held after mr", int'(state), 0);

    // R6 abort during counting
    mr = 1'b1;
    repeat (5) @(negedge clk);
    chk(state == 2'b01, "R6 counting before abort", int'(state), 1);
    mr = 1'b0;
    repeat (3) @(negedge clk);
    chk(state == 2'b00, "R6 count aborted", int'(state), 0);
    repeat (PO + 5) @(negedge clk);
    chk(pwr_en == 0, "R6 no power after abort", int'(pwr_en), 0);

    finish_run();
  end
endmodule